// File: doc/BRIEF.md
# Critical-Word-First Line Refill Sequencer

This block sits between a cache and a slow main memory that returns one word per request. When the cache misses, the block receives the line's block address, the offset of the word the processor is waiting for, and an ordering choice. It then requests the line's words from memory one at a time. Every returned word is written into a line buffer. The demanded word goes to the processor in the same cycle it comes back from memory, with a one-cycle restart pulse, so the processor can run while the rest of the line is still arriving.

Two orderings are available. In wrapped mode the demanded word is requested first and the order wraps around the line. In ascending mode the words are requested in natural order, and the processor is released when the demanded word arrives. While the fill is running, a probe port tells the processor whether a word of the line being filled is already present or whether it must stall. The line is flagged valid only when every word has been written. The block handles one miss at a time. Tag lookup and victim selection belong to the surrounding cache.

Top module: `cwf_refill`

## Requirements
- R1: After reset, `busy`, `line_valid`, `mem_req_valid` and `cpu_restart` are low, and a probe with `acc_valid` high reports `acc_stall` high because no word is present.
- R2: With `miss_mode` = 1 (wrapped), the word offsets requested are m, m+1, m+2, m+3 modulo 4, where m is `miss_off`. Each `mem_req_addr` is {block address, offset} with the offset in the two low bits.
- R3: With `miss_mode` = 0 (ascending), the word offsets requested are 0, 1, 2, 3, whatever `miss_off` is.
- R4: Only one memory request is outstanding. `mem_req_valid` is a single-cycle pulse, and the next pulse comes only in the cycle after the previous word's `mem_rsp_valid`.
- R5: `cpu_restart` is high in the same cycle that the response for the demanded offset is presented, and `cpu_data` carries that word. With a memory latency of L cycles from the accepted request to the response, release comes L + k·(L+1) cycles after the miss is accepted, where k is the demanded word's position in the request order.
- R6: `cpu_restart` pulses exactly once per accepted miss.
- R7: Each returned word is stored at its own offset, and after the fill a probe of offset i returns that word with no stall.
- R8: `line_valid` stays low until the clock edge that writes the fourth word and is high from then on. A new miss clears it.
- R9: During a fill, `acc_stall` is high for a probed offset whose word has not yet arrived, and low, with correct `acc_data`, once that word has arrived.
- R10: A `miss_valid` presented while `busy` is high is ignored. The request order, the number of restarts and the line contents stay those of the miss in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | Miss request, accepted when not busy |
| miss_blk | input | ADDR_W | Block address of the missing line |
| miss_off | input | OFF_W | Offset of the demanded word |
| miss_mode | input | 1 | 1 = wrapped demanded-first, 0 = ascending |
| busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | One-cycle word request to memory |
| mem_req_addr | output | ADDR_W+OFF_W | Word address of the request |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_data | input | DATA_W | Returned word |
| cpu_restart | output | 1 | One-cycle processor release |
| cpu_data | output | DATA_W | Demanded word forwarded to the processor |
| acc_valid | input | 1 | Probe of a word in the line |
| acc_off | input | OFF_W | Offset probed |
| acc_stall | output | 1 | Probed word not yet present |
| acc_data | output | DATA_W | Probed word from the line buffer |
| line_valid | output | 1 | Whole line written |

## Verification
The hardest states to reach are the windows inside a fill: the cycles just before and just after one particular word has landed while the others are still missing, and a second miss that arrives while the first is in progress. The bench drives a memory model with a fixed 64-cycle latency and times its probes from the cycle the miss is accepted. This lets it hit the cycles before and after the demanded word arrives in wrapped mode, and the cycle around the final write. It also injects a conflicting miss in the middle of a fill and relies on the request-order scoreboard and the restart count to expose any effect. All four offsets are run in both modes, and each release cycle is compared with the latency formula.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fill_st_e;

  typedef enum logic {
    ORD_ASCEND = 1'b0,
    ORD_WRAP   = 1'b1
  } fill_ord_e;
endpackage

// File: rtl/cwf_order.sv
module cwf_order
  import cwf_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  fill_ord_e        ord,
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W-1:0] step,
  output logic [OFF_W-1:0] off
);
  // line size is a power of two, so the sum wraps modulo the word count
  always_comb begin
    if (ord == ORD_WRAP) off = start + step;
    else                 off = step;
  end
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic             rsp_valid,
  input  logic [OFF_W-1:0] cur_off,
  input  logic [OFF_W-1:0] want_off,
  output logic             busy,
  output logic             accept,
  output logic             req_valid,
  output logic             take,
  output logic             last,
  output logic             restart,
  output logic [OFF_W-1:0] step
);
  localparam logic [OFF_W-1:0] LAST_STEP = OFF_W'(WORDS - 1);

  fill_st_e         st_q, st_d;
  logic [OFF_W-1:0] step_q, step_d;
  logic             sent_q, sent_d;
  logic             step_en;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = (st_q == ST_IDLE) && miss_valid;
  assign req_valid = (st_q == ST_REQ);
  assign take      = (st_q == ST_WAIT) && rsp_valid;
  assign last      = take && (step_q == LAST_STEP);
  assign restart   = take && (cur_off == want_off);
  assign step      = step_q;
  assign step_en   = accept || (take && !last);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (miss_valid) st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (take) st_d = last ? ST_IDLE : ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_d = step_q;
    if (accept)       step_d = '0;
    else if (step_en) step_d = step_q + 1'b1;
  end

  always_comb begin
    sent_d = sent_q;
    if (accept)       sent_d = 1'b0;
    else if (restart) sent_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  // R4: a request pulse is never followed directly by another
  a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6: at most one release between two accepted misses
  a_r6_one_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !sent_q);

  // R4: no new miss is taken while a word is still awaited
  a_r4_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !accept);
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 64,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_end,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_here,
  output logic              line_valid
);
  logic [DATA_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  here_q, here_d;
  logic              lv_q, lv_d;

  always_comb begin
    here_d = here_q;
    if (clr)        here_d = '0;
    else if (wr_en) here_d[wr_off] = 1'b1;
  end

  always_comb begin
    lv_d = lv_q;
    if (clr)           lv_d = 1'b0;
    else if (fill_end) lv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      here_q <= '0;
      lv_q   <= 1'b0;
    end else begin
      here_q <= here_d;
      lv_q   <= lv_d;
    end
  end

  // data storage carries no reset; presence bits qualify it
  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (wr_en && (wr_off == OFF_W'(i))) word_q[i] <= wr_data;
    end
  end

  assign rd_data    = word_q[rd_off];
  assign rd_here    = here_q[rd_off];
  assign line_valid = lv_q;

  // R8: the line is flagged only with every word present
  a_r8_valid_full: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> (&here_q));

  // R8: the flag rises only on the edge of the final write
  a_r8_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_q) |-> $past(wr_en));
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64,
  parameter int WORDS  = 4,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_blk,
  input  logic [OFF_W-1:0]        miss_off,
  input  logic                    miss_mode,
  output logic                    busy,
  output logic                    mem_req_valid,
  output logic [ADDR_W+OFF_W-1:0] mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    cpu_restart,
  output logic [DATA_W-1:0]       cpu_data,
  input  logic                    acc_valid,
  input  logic [OFF_W-1:0]        acc_off,
  output logic                    acc_stall,
  output logic [DATA_W-1:0]       acc_data,
  output logic                    line_valid
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [ADDR_W-1:0] blk_q;
  logic [OFF_W-1:0]  off_q;
  fill_ord_e         ord_q;
  logic              accept, take, last;
  logic [OFF_W-1:0]  step, req_off;
  logic              here;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_ff @(posedge clk) begin
    if (accept) begin
      blk_q <= miss_blk;
      off_q <= miss_off;
      ord_q <= fill_ord_e'(miss_mode);
    end
  end

  cwf_ctrl #(.WORDS(WORDS), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .miss_valid (miss_valid),
    .rsp_valid  (mem_rsp_valid),
    .cur_off    (req_off),
    .want_off   (off_q),
    .busy       (busy),
    .accept     (accept),
    .req_valid  (mem_req_valid),
    .take       (take),
    .last       (last),
    .restart    (cpu_restart),
    .step       (step)
  );

  cwf_order #(.OFF_W(OFF_W)) u_order (
    .ord   (ord_q),
    .start (off_q),
    .step  (step),
    .off   (req_off)
  );

  cwf_line_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clr        (accept),
    .wr_en      (take),
    .wr_off     (req_off),
    .wr_data    (mem_rsp_data),
    .fill_end   (last),
    .rd_off     (acc_off),
    .rd_data    (acc_data),
    .rd_here    (here),
    .line_valid (line_valid)
  );

  assign mem_req_addr = {blk_q, req_off};
  assign cpu_data     = mem_rsp_data;
  assign acc_stall    = acc_valid && !here;

  // R2: wrapped fill asks for the demanded word before any other
  a_r2_demand_first: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req_valid && (ord_q == ORD_WRAP) && (step == '0)) |-> (req_off == off_q));

  // R5: release only alongside a memory response
  a_r5_restart_on_rsp: assert property (@(posedge clk) disable iff (!rst_s_n)
    cpu_restart |-> mem_rsp_valid);

  // R9: a complete line never stalls a probe
  a_r9_valid_no_stall: assert property (@(posedge clk) disable iff (!rst_s_n)
    (line_valid && acc_valid) |-> !acc_stall);

  // R10: a miss during a fill leaves the captured miss untouched
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && miss_valid && !last) |=> ($stable(blk_q) && $stable(off_q) && busy));
endmodule

// File: tb/cwf_refill_bench.sv
`timescale 1ns/100ps
module cwf_refill_bench;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 64;
  localparam int OFF_W  = 2;
  localparam int LAT    = 64;  // 4 address + 56 access + 4 return cycles

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    miss_valid = 1'b0;
  logic [ADDR_W-1:0]       miss_blk = '0;
  logic [OFF_W-1:0]        miss_off = '0;
  logic                    miss_mode = 1'b0;
  logic                    busy;
  logic                    mem_req_valid;
  logic [ADDR_W+OFF_W-1:0] mem_req_addr;
  logic                    mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0]       mem_rsp_data = '0;
  logic                    cpu_restart;
  logic [DATA_W-1:0]       cpu_data;
  logic                    acc_valid = 1'b0;
  logic [OFF_W-1:0]        acc_off = '0;
  logic                    acc_stall;
  logic [DATA_W-1:0]       acc_data;
  logic                    line_valid;

  int     n_chk = 0;
  int     n_fail = 0;
  int     n_restart = 0;
  longint cyc = 0;

  logic [ADDR_W+OFF_W-1:0] addr_exp_q[$];
  longint                  rel_cyc_q[$];
  logic [DATA_W-1:0]       rel_dat_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cwf_refill u_cwf_refill (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_blk(miss_blk),
    .miss_off(miss_off), .miss_mode(miss_mode), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cpu_restart(cpu_restart), .cpu_data(cpu_data), .acc_valid(acc_valid),
    .acc_off(acc_off), .acc_stall(acc_stall), .acc_data(acc_data),
    .line_valid(line_valid)
  );

  function automatic logic [DATA_W-1:0] mword(input logic [ADDR_W+OFF_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return {w * 32'h9E37_79B1, w ^ 32'h5A5A_0F0F};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_cyc(input longint t);
    do @(negedge clk); while (cyc < t);
    #1;
  endtask

  // memory model: checks each request against the expected order (R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        logic [ADDR_W+OFF_W-1:0] a;
        a = mem_req_addr;
        if (addr_exp_q.size() == 0) chk(1'b0, "R2/R3 unexpected request", 64'(a), 64'hx);
        else begin
          logic [ADDR_W+OFF_W-1:0] e;
          e = addr_exp_q.pop_front();
          chk(a == e, "R2/R3 request order", 64'(a), 64'(e));
        end
        repeat (LAT) begin
          @(negedge clk);
          chk(!mem_req_valid, "R4 request while outstanding", 64'(mem_req_valid), 64'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mword(a);
      end
    end
  end

  // restart monitor: scoreboard of release cycle and data (R5, R6)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (cpu_restart) begin
        n_restart++;
        if (rel_cyc_q.size() == 0) chk(1'b0, "R6 extra restart", 64'(cyc), 64'hx);
        else begin
          longint       ec;
          logic [63:0]  ed;
          ec = rel_cyc_q.pop_front();
          ed = rel_dat_q.pop_front();
          chk(cyc == ec, "R5 release cycle", 64'(cyc), 64'(ec));
          chk(cpu_data == ed, "R5 forwarded word", cpu_data, ed);
        end
      end
    end
  end

  task automatic do_miss(input logic [ADDR_W-1:0] blk, input logic [OFF_W-1:0] off,
                         input logic mode, input bit probe, input bit inject);
    longint t0;
    int     pos;
    int     r0;
    pos = 0;
    for (int k = 0; k < 4; k++) begin
      logic [OFF_W-1:0] o;
      o = mode ? OFF_W'(off + OFF_W'(k)) : OFF_W'(k);
      addr_exp_q.push_back({blk, o});
      if (o == off) pos = k;
    end
    r0 = n_restart;
    @(negedge clk);
    miss_valid = 1'b1; miss_blk = blk; miss_off = off; miss_mode = mode;
    @(posedge clk);
    #1;
    t0 = cyc;
    miss_valid = 1'b0;
    rel_cyc_q.push_back(t0 + LAT + longint'(pos) * (LAT + 1));
    rel_dat_q.push_back(mword({blk, off}));
    if (probe) begin
      wait_cyc(t0 + 2);
      acc_valid = 1'b1; acc_off = off;
      #0.5;
      chk(acc_stall == 1'b1, "R9 stall before arrival", 64'(acc_stall), 64'd1);
      wait_cyc(t0 + LAT + 1);
      acc_off = off;
      #0.5;
      chk(acc_stall == 1'b0, "R9 no stall after arrival", 64'(acc_stall), 64'd0);
      chk(acc_data == mword({blk, off}), "R9 early word data", acc_data, mword({blk, off}));
      acc_off = off + 1'b1;
      #0.5;
      chk(acc_stall == 1'b1, "R9 stall on missing word", 64'(acc_stall), 64'd1);
      acc_valid = 1'b0;
    end
    if (inject) begin
      wait_cyc(t0 + 10);
      miss_valid = 1'b1; miss_blk = ~blk; miss_off = off + 1'b1; miss_mode = ~mode;
      @(negedge clk);
      miss_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy kept", 64'(busy), 64'd1);
    end
    wait_cyc(t0 + LAT + 3 * (LAT + 1));
    chk(line_valid == 1'b0, "R8 valid before last write", 64'(line_valid), 64'd0);
    @(negedge clk);
    #1;
    chk(line_valid == 1'b1, "R8 valid after last write", 64'(line_valid), 64'd1);
    chk(busy == 1'b0, "R4 idle after fill", 64'(busy), 64'd0);
    repeat (2) @(negedge clk);
    chk(n_restart == r0 + 1, "R6 one restart per miss", 64'(n_restart - r0), 64'd1);
    chk(addr_exp_q.size() == 0, "R2/R3/R10 all requests seen", 64'(addr_exp_q.size()), 64'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_off = OFF_W'(i);
      #1;
      chk(acc_stall == 1'b0, "R7 no stall on full line", 64'(acc_stall), 64'd0);
      chk(acc_data == mword({blk, OFF_W'(i)}), "R7 stored word", acc_data,
          mword({blk, OFF_W'(i)}));
    end
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc_valid = 1'b1; acc_off = '0;
    #1;
    chk(busy == 1'b0, "R1 busy low", 64'(busy), 64'd0);
    chk(line_valid == 1'b0, "R1 line_valid low", 64'(line_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 no request", 64'(mem_req_valid), 64'd0);
    chk(cpu_restart == 1'b0, "R1 no restart", 64'(cpu_restart), 64'd0);
    chk(acc_stall == 1'b1, "R1 empty line stalls", 64'(acc_stall), 64'd1);
    acc_valid = 1'b0;

    // R3 ascending order, every offset
    for (int o = 0; o < 4; o++) do_miss(26'h12_3400 + 26'(o), OFF_W'(o), 1'b0, 1'b0, 1'b0);
    // R2 wrapped order, every offset
    for (int o = 0; o < 4; o++) do_miss(26'h2A_5500 + 26'(o), OFF_W'(o), 1'b1, 1'b0, 1'b0);
    // R9 probes inside a wrapped fill
    do_miss(26'h01_0F0F, 2'd2, 1'b1, 1'b1, 1'b0);
    // R10 conflicting miss during a fill
    do_miss(26'h3C_0001, 2'd1, 1'b0, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule